// File: doc/BRIEF.md
# Two-Stage Parallel Converter Code Register

This block is the clocked digital front end of a 12-bit converter whose code arrives over an 8-bit parallel bus. A host writes the word in two parts. The low byte goes in under its own active-low select. The upper four bits go in under a second select and ride on the low half of the bus. Both parts land in an input register. A separate active-low load strobe then copies the whole 12-bit input register into the output register, which drives the converter code.

All strobes are asynchronous to the system clock. They pass through a two-flop synchronizer. The data bus is delayed by the same number of stages, so that data and strobes stay aligned. Each register stage is "transparent" while its enable condition holds: it is rewritten on every clock while the condition is true, and it keeps its value once the condition ends.

If the load strobe is held low together with a nibble write, the new nibble and the output update on the same clock. This lets a host update the output with two bus writes by tying the load strobe to the nibble select.

Top module: `dac_code_front`

## Requirements
- R1: While reset `rstN` is low, and after it is released with no strobe active, `dacCode` is zero and both halves of the input register are zero.
- R2: While `selLoN` and `wrN` are both low, the low byte of the input register follows `busIn[7:0]` on every clock. It keeps its value once either signal goes high.
- R3: While `selHiN` and `wrN` are both low, the upper nibble of the input register (code bits 11:8) follows `busIn[3:0]` on every clock. `busIn[7:4]` has no effect on the stored word.
- R4: While `loadN` is low, `dacCode` follows the full input register on every clock. After `loadN` rises, it holds the last value taken.
- R5: `loadN` acts independently of `wrN` and the selects. A load with no write transfers the stored word. A write with `loadN` high leaves `dacCode` unchanged.
- R6: When `loadN` is low during a nibble write, `dacCode` shows the new nibble on the same clock that the input register takes it.
- R7: With both selects high and `loadN` high, neither the input register nor `dacCode` changes.
- R8: A strobe edge at the pins takes effect at the third rising clock edge after it: two synchronizer stages plus the register.
- R9: With both selects low during a write, the low byte takes `busIn[7:0]` and the nibble takes `busIn[3:0]` in the same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 8 | Parallel data bus |
| selLoN | input | 1 | Active-low select for the low byte |
| selHiN | input | 1 | Active-low select for the upper nibble |
| wrN | input | 1 | Active-low write strobe |
| loadN | input | 1 | Active-low output load strobe |
| dacCode | output | 12 | Output register value driving the converter |

## Verification
The assertions check on every cycle the behaviour seen after the synchronizer:
- each input half holds when its write enable is off (R2, R3);
- the output equals the input register one clock after a load enable, and holds otherwise (R4, R5, R6);
- nothing changes when all enables are idle (R7);
- reset clears the output (R1).

Only the bench scenarios can show the behaviour seen at the pins:
- the exact three-edge latency (R8);
- that bus bits 7:4 never reach the word (R3);
- that a transparent stage tracks a bus that changes while the strobe stays low;
- that randomly mixed strobe combinations produce the right word across long sequences.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;

  // Enables seen by the datapath after synchronization, all active high
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic loadDac;
  } strobe_t;

endpackage

// File: rtl/dac_code_sync.sv
// Multi-stage, multi-bit delay/synchronizer chain with a reset value
module dac_code_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/dac_code_ctrl.sv
// Decodes the synchronized active-low pins into datapath enables
module dac_code_ctrl
  import dac_code_pkg::*;
(
  input  logic    selLoS,
  input  logic    selHiS,
  input  logic    wrS,
  input  logic    loadS,
  output strobe_t strobes
);

  always_comb begin
    strobes.loadLo  = !selLoS && !wrS;
    strobes.loadHi  = !selHiS && !wrS;
    strobes.loadDac = !loadS;
  end

endmodule

// File: rtl/dac_code_dpath.sv
// Input register (byte + nibble) and output register
module dac_code_dpath
  import dac_code_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [LO_W-1:0]   busD,
  output logic [CODE_W-1:0] inWord,
  output logic [CODE_W-1:0] outWord
);

  logic [LO_W-1:0]   loQ, loNext;
  logic [HI_W-1:0]   hiQ, hiNext;
  logic [CODE_W-1:0] wordNext;

  always_comb begin
    loNext   = strobes.loadLo ? busD : loQ;
    hiNext   = strobes.loadHi ? busD[HI_W-1:0] : hiQ;
    // the output sees the word as it will be after this clock, so a
    // nibble write with the load active updates the output in step
    wordNext = {hiNext, loNext};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ     <= '0;
      hiQ     <= '0;
      outWord <= '0;
    end else begin
      loQ <= loNext;
      hiQ <= hiNext;
      if (strobes.loadDac) outWord <= wordNext;
    end
  end

  assign inWord = {hiQ, loQ};

endmodule

// File: rtl/dac_code_front.sv
module dac_code_front
  import dac_code_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_W        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LO_W-1:0]   busIn,
  input  logic              selLoN,
  input  logic              selHiN,
  input  logic              wrN,
  input  logic              loadN,
  output logic [CODE_W-1:0] dacCode
);

  logic [3:0]        pinSync;
  logic [LO_W-1:0]   busSync;
  strobe_t           strobes;
  logic [CODE_W-1:0] inWord;

  dac_code_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_pinSync (
    .clk(clk), .rstN(rstN),
    .dIn({selLoN, selHiN, wrN, loadN}), .dOut(pinSync)
  );

  // bus delayed by the same depth so it stays aligned with the strobes
  dac_code_sync #(.WIDTH(LO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_busSync (
    .clk(clk), .rstN(rstN), .dIn(busIn), .dOut(busSync)
  );

  dac_code_ctrl u_ctrl (
    .selLoS(pinSync[3]), .selHiS(pinSync[2]),
    .wrS(pinSync[1]), .loadS(pinSync[0]),
    .strobes(strobes)
  );

  dac_code_dpath #(.LO_W(LO_W), .HI_W(HI_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busD(busSync),
    .inWord(inWord), .outWord(dacCode)
  );

endmodule

// File: rtl/dac_code_front_chk.sv
module dac_code_front_chk
  import dac_code_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = LO_W + HI_W
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strobes,
  input logic [CODE_W-1:0] inWord,
  input logic [CODE_W-1:0] dacCode
);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (dacCode == '0));

  // R2
  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLo |=> $stable(inWord[LO_W-1:0]));

  // R3
  a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadHi |=> $stable(inWord[CODE_W-1:LO_W]));

  // R4 and R6: a load enable leaves the output equal to the new input word
  a_r4_follow: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDac |=> (dacCode == inWord));

  // R5
  a_r5_no_load_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDac |=> $stable(dacCode));

  // R7
  a_r7_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadLo && !strobes.loadHi && !strobes.loadDac)
      |=> ($stable(dacCode) && $stable(inWord)));

endmodule

bind dac_code_front dac_code_front_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes),
  .inWord(inWord), .dacCode(dacCode)
);

// File: tb/dac_code_front_tb.sv
`timescale 1ns/1ps
module dac_code_front_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busIn = 8'h00;
  logic        selLoN = 1'b1, selHiN = 1'b1, wrN = 1'b1, loadN = 1'b1;
  logic [11:0] dacCode;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0]  expLo = 8'h00;
  logic [3:0]  expHi = 4'h0;
  logic [11:0] expDac = 12'h000;

  always #4 clk = ~clk;   // 125 MHz

  dac_code_front dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn),
    .selLoN(selLoN), .selHiN(selHiN), .wrN(wrN), .loadN(loadN),
    .dacCode(dacCode)
  );

  function automatic logic [11:0] wordOf(input logic [3:0] h, input logic [7:0] l);
    return {h, l};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: dacCode=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic releaseAll();
    selLoN = 1'b1; selHiN = 1'b1; wrN = 1'b1; loadN = 1'b1;
  endtask

  // one bus operation; flags are active-high requests
  task automatic doOp(input bit sLo, input bit sHi, input bit w, input bit l,
                      input logic [7:0] b, input string req);
    @(negedge clk);
    busIn = b; selLoN = !sLo; selHiN = !sHi; wrN = !w; loadN = !l;
    if (sLo && w) expLo = b;
    if (sHi && w) expHi = b[3:0];
    if (l) expDac = wordOf(expHi, expLo);
    repeat (4) @(negedge clk);
    check(req, dacCode, expDac);            // transparent phase
    releaseAll();
    repeat (4) @(negedge clk);
    check(req, dacCode, expDac);            // after release
  endtask

  // check the stored word by moving it to the output with a plain load
  task automatic probe(input string req);
    doOp(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 in reset", dacCode, 12'h000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", dacCode, 12'h000);
    probe("R1 input register zero");

    // R2 / R5: write low byte without load, output unchanged
    doOp(1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, "R5 write without load");
    probe("R2 low byte stored");

    // R3: upper bus bits ignored for the nibble
    doOp(1'b0, 1'b1, 1'b1, 1'b0, 8'hF3, "R3 nibble write");
    probe("R3 upper bus bits ignored");

    // R6: nibble write with load active
    doOp(1'b0, 1'b1, 1'b1, 1'b1, 8'h5C, "R6 nibble plus load");

    // R9: both selects together
    doOp(1'b1, 1'b1, 1'b1, 1'b1, 8'h9E, "R9 both selects");

    // R7: selects high, write and bus toggling, no load
    doOp(1'b0, 1'b0, 1'b1, 1'b0, 8'h11, "R7 idle selects");
    probe("R7 stored word unchanged");

    // R2 / R4: transparent tracking while strobes stay low
    @(negedge clk);
    selLoN = 1'b0; wrN = 1'b0; loadN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      busIn = 8'h30 + 8'(k * 7);
      expLo = busIn;
      expDac = wordOf(expHi, expLo);
      repeat (4) @(negedge clk);
      check("R2 R4 transparent tracking", dacCode, expDac);
    end
    releaseAll();
    busIn = 8'hFF;
    repeat (4) @(negedge clk);
    check("R4 hold after load rises", dacCode, expDac);

    // R8: latency of exactly three rising edges
    @(negedge clk);
    busIn = 8'h42; selLoN = 1'b0; wrN = 1'b0; loadN = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 before third edge", dacCode, expDac);
    expLo = 8'h42;
    expDac = wordOf(expHi, expLo);
    @(negedge clk);
    check("R8 at third edge", dacCode, expDac);
    releaseAll();
    repeat (4) @(negedge clk);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      doOp(r[0], r[1], r[2], r[3], 8'($urandom), "R2 R3 R5 R7 random");
    end
    probe("R9 final stored word");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule